// File: doc/BRIEF.md
# Flash Program and Erase Controller

This block runs the write-side operations of a small on-chip flash model: it programs one 16-bit half-word, clears one page back to ones, or clears the whole main array back to ones. The cells are modelled inside the block as a main array of pages and a separate information region. Software sets an address and a data word through four register slots, then writes an operation code together with a start bit. The controller runs the operation for a fixed number of pulses of a slow, fixed-rate tick, so operation length does not depend on the bus clock. When the operation finishes it sets a sticky completion flag, which can drive an interrupt line.

A program request is checked before it starts. If the target is not an erased half-word, is not half-word aligned, or lies past the end of the information region, the request sets an error flag instead of running. A start is also refused while the oscillator-ready input is low, and a start written while an operation is running is dropped. The operation code, address and data are copied when an operation starts, so software may rewrite the registers while busy.

Top module: `nvm_pe_ctrl`

## Requirements
- R1: After reset every main and information half-word reads 0xFFFF on `rd_data`, and the status slot (index 3: bit0 busy, bit1 done, bit2 error) reads zero.
- R2: Writing slot 0 with bits[1:0]=1 (program) and bit2=1 (start) stores DATA (slot 2, bits[15:0]) at the byte address in ADDR (slot 1). ADDR bit8=1 selects the information region, and bits[7:1] give the half-word index. Busy stays high for exactly 4 tick pulses.
- R3: A program start that targets a half-word not reading 0xFFFF, an odd address, or an information index of 8 or more sets the error flag (status bit2), never raises busy, and leaves the cell unchanged.
- R4: A start written while `osc_rdy` is low is refused: busy stays low, no flag is set and the array is unchanged.
- R5: A start written while busy is ignored. The running operation completes unchanged and the second operation never runs.
- R6: Operation code 2 (page erase) sets to 0xFFFF the 16 half-words of the page picked by ADDR bits[7:5], and no other main half-word. It holds busy for exactly 32 tick pulses. With ADDR bit8 set, it clears the information region instead.
- R7: Operation code 3 (mass erase) sets every main half-word to 0xFFFF, leaves the information region untouched, and holds busy for exactly 64 tick pulses.
- R8: The done flag (status bit1) is set on the same clock edge that busy falls. Done and error stay set until software writes 1 to their status bits.
- R9: `irq` is high exactly when done is set and the interrupt enable (slot 0 bit3) is set.
- R10: Address and data written while an operation is running do not affect that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse from the fixed-rate timing source |
| osc_rdy | input | 1 | High while the internal oscillator runs |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register slot: 0 control, 1 address, 2 data, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the slot selected by reg_idx |
| rd_addr | input | 9 | Byte address for array reads, bit8 selects the information region |
| rd_data | output | 16 | Half-word at rd_addr |
| irq | output | 1 | End-of-operation interrupt |

## Verification
A timer that loses or gains a count shows up at the status slot. There, busy falls one tick early or late, and the tick total seen during each operation differs from 4, 32 or 64. A bad operand snapshot or a wrong page decode shows at `rd_data` on the first read after busy falls, as a wrong or missing value at the target or a cleared neighbour. A wrong flag state shows in the status slot and on `irq` in the cycle after the edge that should have changed it.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PROG = 2'd1,
        OP_PAGE = 2'd2,
        OP_MASS = 2'd3
    } nvm_op_e;

    localparam logic [1:0] RIDX_CTRL = 2'd0;
    localparam logic [1:0] RIDX_ADDR = 2'd1;
    localparam logic [1:0] RIDX_DATA = 2'd2;
    localparam logic [1:0] RIDX_STAT = 2'd3;

    localparam logic [15:0] ERASED_HW = 16'hFFFF;

endpackage

// File: rtl/nvm_tick_timer.sv
module nvm_tick_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             busy,
    output logic             fin
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        fin   = 1'b0;
        if (load) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = load_val;
        end else if (tmr_q.busy && tick) begin
            if (tmr_q.cnt == CNT_W'(1)) begin
                tmr_d.busy = 1'b0;
                tmr_d.cnt  = '0;
                fin        = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = tmr_q.busy;

endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array
    import nvm_pkg::*;
#(
    parameter int PAGES   = 8,
    parameter int PAGE_HW = 16,
    parameter int INFO_HW = 8,
    parameter int AW      = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  nvm_op_e       op,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    input  logic [AW-1:0] rd_addr,
    output logic [15:0]   rd_data,
    input  logic [AW-1:0] chk_addr,
    output logic [15:0]   chk_data
);
    localparam int MAIN_HW = PAGES * PAGE_HW;
    localparam int MIDX_W  = $clog2(MAIN_HW);
    localparam int OFF_W   = $clog2(PAGE_HW);
    localparam int IIDX_W  = $clog2(INFO_HW);

    logic [15:0] main_d [MAIN_HW];
    logic [15:0] main_q [MAIN_HW];
    logic [15:0] info_d [INFO_HW];
    logic [15:0] info_q [INFO_HW];

    logic [MIDX_W-1:0] wr_idx;
    logic [MIDX_W-1:0] rd_idx;
    logic [MIDX_W-1:0] ck_idx;

    assign wr_idx = addr[MIDX_W:1];
    assign rd_idx = rd_addr[MIDX_W:1];
    assign ck_idx = chk_addr[MIDX_W:1];

    always_comb begin
        if (!rd_addr[AW-1])                 rd_data = main_q[rd_idx];
        else if (int'(rd_idx) < INFO_HW)    rd_data = info_q[rd_idx[IIDX_W-1:0]];
        else                                rd_data = ERASED_HW;
    end

    always_comb begin
        if (!chk_addr[AW-1])                chk_data = main_q[ck_idx];
        else if (int'(ck_idx) < INFO_HW)    chk_data = info_q[ck_idx[IIDX_W-1:0]];
        else                                chk_data = ERASED_HW;
    end

    always_comb begin
        main_d = main_q;
        info_d = info_q;
        if (commit) begin
            case (op)
                OP_PROG: begin
                    if (!addr[AW-1])                  main_d[wr_idx] = wdata;
                    else if (int'(wr_idx) < INFO_HW)  info_d[wr_idx[IIDX_W-1:0]] = wdata;
                end
                OP_PAGE: begin
                    if (addr[AW-1]) begin
                        for (int i = 0; i < INFO_HW; i++) info_d[i] = ERASED_HW;
                    end else begin
                        for (int i = 0; i < MAIN_HW; i++)
                            if ((i / PAGE_HW) == int'(wr_idx[MIDX_W-1:OFF_W]))
                                main_d[i] = ERASED_HW;
                    end
                end
                OP_MASS: begin
                    for (int i = 0; i < MAIN_HW; i++) main_d[i] = ERASED_HW;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAIN_HW; i++) main_q[i] <= ERASED_HW;
            for (int i = 0; i < INFO_HW; i++) info_q[i] <= ERASED_HW;
        end else begin
            main_q <= main_d;
            info_q <= info_d;
        end
    end

endmodule

// File: rtl/nvm_pe_ctrl.sv
module nvm_pe_ctrl
    import nvm_pkg::*;
#(
    parameter int PAGES      = 8,
    parameter int PAGE_HW    = 16,
    parameter int INFO_HW    = 8,
    parameter int PROG_TICKS = 4,
    parameter int PAGE_TICKS = 32,
    parameter int MASS_TICKS = 64,
    localparam int AW        = $clog2(PAGES * PAGE_HW) + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          osc_rdy,
    input  logic          reg_we,
    input  logic [1:0]    reg_idx,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic [AW-1:0] rd_addr,
    output logic [15:0]   rd_data,
    output logic          irq
);
    localparam int CNT_W = $clog2(MASS_TICKS + 1);

    typedef struct packed {
        nvm_op_e       op;
        logic          ie;
        logic [AW-1:0] addr;
        logic [15:0]   data;
        logic          done;
        logic          perr;
        nvm_op_e       run_op;
        logic [AW-1:0] run_addr;
        logic [15:0]   run_data;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic             busy;
    logic             fin;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic [15:0]      chk_data;
    logic             done_flag;
    logic             perr_flag;

    nvm_op_e req_op;
    logic    go;
    logic    prog_bad;

    nvm_tick_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .tick     (tick),
        .busy     (busy),
        .fin      (fin)
    );

    nvm_cell_array #(
        .PAGES   (PAGES),
        .PAGE_HW (PAGE_HW),
        .INFO_HW (INFO_HW),
        .AW      (AW)
    ) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (fin),
        .op       (ctl_q.run_op),
        .addr     (ctl_q.run_addr),
        .wdata    (ctl_q.run_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .chk_addr (ctl_q.addr),
        .chk_data (chk_data)
    );

    always_comb begin
        ctl_d    = ctl_q;
        load     = 1'b0;
        load_val = '0;
        req_op   = nvm_op_e'(reg_wdata[1:0]);
        go       = reg_we && (reg_idx == RIDX_CTRL) && reg_wdata[2]
                   && !busy && osc_rdy && (req_op != OP_NONE);
        prog_bad = ctl_q.addr[0]
                   || (ctl_q.addr[AW-1] && (int'(ctl_q.addr[AW-2:1]) >= INFO_HW))
                   || (chk_data != ERASED_HW);

        if (reg_we) begin
            case (reg_idx)
                RIDX_CTRL: begin
                    ctl_d.op = req_op;
                    ctl_d.ie = reg_wdata[3];
                end
                RIDX_ADDR: ctl_d.addr = reg_wdata[AW-1:0];
                RIDX_DATA: ctl_d.data = reg_wdata[15:0];
                default: begin
                    if (reg_wdata[1]) ctl_d.done = 1'b0;
                    if (reg_wdata[2]) ctl_d.perr = 1'b0;
                end
            endcase
        end

        if (go) begin
            if ((req_op == OP_PROG) && prog_bad) begin
                ctl_d.perr = 1'b1;
            end else begin
                load           = 1'b1;
                ctl_d.run_op   = req_op;
                ctl_d.run_addr = ctl_q.addr;
                ctl_d.run_data = ctl_q.data;
                case (req_op)
                    OP_PROG: load_val = CNT_W'(PROG_TICKS);
                    OP_PAGE: load_val = CNT_W'(PAGE_TICKS);
                    default: load_val = CNT_W'(MASS_TICKS);
                endcase
            end
        end

        if (fin) ctl_d.done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_idx)
            RIDX_CTRL: begin
                reg_rdata[1:0] = ctl_q.op;
                reg_rdata[3]   = ctl_q.ie;
            end
            RIDX_ADDR: reg_rdata[AW-1:0] = ctl_q.addr;
            RIDX_DATA: reg_rdata[15:0]   = ctl_q.data;
            default:   reg_rdata[2:0]    = {ctl_q.perr, ctl_q.done, busy};
        endcase
    end

    assign done_flag = ctl_q.done;
    assign perr_flag = ctl_q.perr;
    assign irq       = ctl_q.done & ctl_q.ie;

endmodule

// File: rtl/nvm_pe_ctrl_chk.sv
module nvm_pe_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic osc_rdy,
    input logic busy,
    input logic done_flag,
    input logic perr_flag
);
    // R8
    done_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_flag);

    // R2
    busy_ends_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tick));

    // R4
    no_start_without_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !osc_rdy) |=> !busy);

    // R3
    perr_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perr_flag) |-> !busy);

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> busy);
endmodule

bind nvm_pe_ctrl nvm_pe_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .osc_rdy   (osc_rdy),
    .busy      (busy),
    .done_flag (done_flag),
    .perr_flag (perr_flag)
);

// File: tb/nvm_pe_ctrl_tb.sv
`timescale 1ns/100ps
module nvm_pe_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        osc_rdy = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_idx = 2'd3;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [8:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        irq;

    int compared = 0;
    int mismatched = 0;
    int outstanding = 0;
    int tdiv = 0;
    bit ie = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        tdiv = (tdiv == 2) ? 0 : tdiv + 1;
        tick = (tdiv == 0);
    end

    nvm_pe_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .osc_rdy   (osc_rdy),
        .reg_we    (reg_we),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    // kind: 0 flash read, 1 register read, 2 irq pin
    typedef struct {
        string       req;
        int          kind;
        logic [8:0]  a;
        logic [31:0] exp;
        logic [31:0] mask;
    } item_t;

    item_t sbq[$];

    task automatic push(string req, int kind, logic [8:0] a, logic [31:0] exp, logic [31:0] mask);
        item_t it;
        it.req = req; it.kind = kind; it.a = a; it.exp = exp; it.mask = mask;
        outstanding++;
        sbq.push_back(it);
    endtask

    task automatic exp_flash(string req, logic [8:0] a, logic [15:0] v);
        push(req, 0, a, {16'h0, v}, 32'h0000_FFFF);
    endtask

    task automatic exp_reg(string req, logic [1:0] idx, logic [31:0] v, logic [31:0] m);
        push(req, 1, {7'd0, idx}, v, m);
    endtask

    task automatic exp_irq(string req, logic v);
        push(req, 2, 9'd0, {31'd0, v}, 32'h1);
    endtask

    task automatic sync();
        wait (outstanding == 0);
    endtask

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            item_t it;
            logic [31:0] act;
            wait (sbq.size() > 0);
            it = sbq.pop_front();
            @(negedge clk);
            if (it.kind == 0) rd_addr = it.a;
            else if (it.kind == 1) reg_idx = it.a[1:0];
            #1;
            case (it.kind)
                0:       act = {16'h0, rd_data};
                1:       act = reg_rdata;
                default: act = {31'd0, irq};
            endcase
            compared++;
            if ((act & it.mask) != (it.exp & it.mask)) begin
                mismatched++;
                $display("FAIL %s: actual %h expected %h", it.req, act & it.mask, it.exp & it.mask);
            end
            outstanding--;
        end
    end

    task automatic check_val(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] idx, logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0; reg_idx = 2'd3;
    endtask

    function automatic logic [31:0] ctrl_word(logic [1:0] op, bit start);
        return {28'd0, ie, start, op};
    endfunction

    // start an operation, then count tick pulses seen while busy
    task automatic run_op(string req, logic [1:0] op, int exp_ticks);
        int n = 0;
        int guard = 0;
        wr(2'd0, ctrl_word(op, 1'b1));
        #1;
        while (reg_rdata[0] && guard < 2000) begin
            @(posedge clk);
            if (tick) n++;
            @(negedge clk);
            #1;
            guard++;
        end
        check_val(req, n, exp_ticks);
    endtask

    task automatic wait_idle();
        int guard = 0;
        reg_idx = 2'd3;
        #1;
        while (reg_rdata[0] && guard < 2000) begin
            @(negedge clk);
            #1;
            guard++;
        end
    endtask

    task automatic prog(string req, logic [8:0] a, logic [15:0] v, int exp_ticks);
        wr(2'd1, {23'd0, a});
        wr(2'd2, {16'd0, v});
        run_op(req, 2'd1, exp_ticks);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        exp_reg("R1 status after reset", 2'd3, 32'h0, 32'h7);
        exp_flash("R1 main erased", 9'h000, 16'hFFFF);
        exp_flash("R1 info erased", 9'h100, 16'hFFFF);
        sync();

        // R2 / R8: program main half-word
        prog("R2 program ticks", 9'h010, 16'hA5A5, 4);
        exp_flash("R2 programmed value", 9'h010, 16'hA5A5);
        exp_flash("R2 neighbour untouched", 9'h012, 16'hFFFF);
        exp_reg("R8 done set busy low", 2'd3, 32'h2, 32'h7);
        exp_irq("R9 irq off without enable", 1'b0);
        sync();

        // R9 / R8: enable interrupt, then clear done
        ie = 1'b1;
        wr(2'd0, ctrl_word(2'd0, 1'b0));
        exp_irq("R9 irq with enable and done", 1'b1);
        sync();
        wr(2'd3, 32'h2);
        exp_irq("R9 irq after done cleared", 1'b0);
        exp_reg("R8 done cleared by write one", 2'd3, 32'h0, 32'h7);
        sync();

        // R3: program over non-erased cell
        prog("R3 no busy on dirty cell", 9'h010, 16'h1234, 0);
        exp_reg("R3 error flag", 2'd3, 32'h4, 32'h7);
        exp_flash("R3 cell unchanged", 9'h010, 16'hA5A5);
        sync();
        wr(2'd3, 32'h4);
        // R3: odd address
        prog("R3 no busy on odd address", 9'h021, 16'h4321, 0);
        exp_reg("R3 error flag odd", 2'd3, 32'h4, 32'h7);
        exp_flash("R3 odd target unchanged", 9'h020, 16'hFFFF);
        sync();
        wr(2'd3, 32'h4);

        // R4: oscillator not ready
        osc_rdy = 1'b0;
        prog("R4 refused start", 9'h030, 16'h5555, 0);
        exp_reg("R4 no flags", 2'd3, 32'h0, 32'h7);
        exp_flash("R4 cell unchanged", 9'h030, 16'hFFFF);
        sync();
        osc_rdy = 1'b1;

        // R10 / R5: rewrite operands and request mass erase while busy
        wr(2'd1, 32'h040);
        wr(2'd2, 32'h1111);
        wr(2'd0, ctrl_word(2'd1, 1'b1));
        wr(2'd2, 32'h2222);
        wr(2'd1, 32'h042);
        wr(2'd0, ctrl_word(2'd3, 1'b1));
        wait_idle();
        exp_flash("R10 snapshot data", 9'h040, 16'h1111);
        exp_flash("R10 new address unused", 9'h042, 16'hFFFF);
        exp_flash("R5 mass erase ignored", 9'h010, 16'hA5A5);
        exp_reg("R8 done after op", 2'd3, 32'h2, 32'h7);
        sync();
        wr(2'd3, 32'h2);

        // R6: page erase of page 1
        prog("R2 program page1 first", 9'h020, 16'h7777, 4);
        prog("R2 program page1 last", 9'h03E, 16'h8888, 4);
        wr(2'd1, 32'h02A);
        run_op("R6 page erase ticks", 2'd2, 32);
        exp_flash("R6 page1 first erased", 9'h020, 16'hFFFF);
        exp_flash("R6 page1 last erased", 9'h03E, 16'hFFFF);
        exp_flash("R6 page2 kept", 9'h040, 16'h1111);
        exp_flash("R6 page0 kept", 9'h010, 16'hA5A5);
        sync();

        // R7: mass erase keeps information region
        prog("R2 program info", 9'h104, 16'h0BEE, 4);
        exp_flash("R2 info value", 9'h104, 16'h0BEE);
        sync();
        wr(2'd1, 32'h000);
        run_op("R7 mass erase ticks", 2'd3, 64);
        exp_flash("R7 info preserved", 9'h104, 16'h0BEE);
        exp_flash("R7 page0 erased", 9'h010, 16'hFFFF);
        exp_flash("R7 page2 erased", 9'h040, 16'hFFFF);
        exp_flash("R7 last page erased", 9'h0FE, 16'hFFFF);
        exp_irq("R9 irq after mass erase", 1'b1);
        sync();

        summary();
        $finish;
    end

endmodule